// File: doc/BRIEF.md
# Fetch Thread Status Controller

This block holds the fetch status of every hardware thread in a multithreaded instruction fetch stage. Each cycle it folds together the stall handshakes from four later pipeline stages, redirect requests from the commit and decode stages, a flag showing that the reorder buffer is still flushing, a context-switch flag, and the events of the instruction-cache request path. From these it updates one status register per thread. It also keeps each thread's redirect PC, next PC and micro-PC, a global flag showing that the cache has refused a request, and a flag showing that the fetch stage as a whole has work.

The fetch datapath reads the per-thread status to decide which thread may issue a cache line request. It reports the outcome of each request (accepted or refused), the retry pulse and the responses back into this block. Only threads marked active in `thr_active` are updated. A thread outside that mask keeps its status, its stall bits and its PCs.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every thread takes status code 0 (Running), its stall bits clear, `cache_blocked` and `stage_active` go to 0, PC goes to RESET_PC, next PC to RESET_PC+INST_BYTES and micro-PC to 0. The status codes are 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 waiting for a cache response, 5 waiting for a cache retry, 6 cache fill done, 7 trap pending and 8 quiesce pending. Each thread's code sits in `thr_state[4t+3:4t]`.
- R2: Each stage has one sticky stall bit per thread. The bit sits at index s*N_THR+t of `stg_block`/`stg_unblock`, with s = 0 decode, 1 rename, 2 execute, 3 commit. A block pulse sets the bit and an unblock pulse clears it. An unblock while the bit is clear, or in the same cycle as a block, is a protocol error.
- R3: A commit squash for a thread loads `cmt_pc`, `cmt_npc` and `cmt_upc` and moves the thread to Squashing. It overrides every other event for that thread in that cycle.
- R4: When there is no commit squash, `rob_squashing[t]` holds thread t in Squashing. Decode squashes, stalls and cache events for that thread are ignored.
- R5: A decode squash loads the decode PCs and moves the thread to Squashing only if the thread is not already in Squashing. Otherwise it has no effect.
- R6: If any stall bit (after this cycle's pulses) or `ctx_switch` is set, the thread goes to Blocked. This does not happen in codes 4 and 5.
- R7: When there is no squash and no stall, a thread in Blocked or Squashing returns to Running at the next edge.
- R8: A request from a thread that is Running (after R3–R7) while `cache_blocked` is 0 is taken. If accepted, the thread goes to code 4 and its tag is stored. If refused, the thread goes to code 5 and `cache_blocked` is set. Any other request is ignored.
- R9: A retry pulse while `cache_blocked` is set clears the flag, and moves the thread that owns the retry from code 5 to code 4.
- R10: A response is used only if the thread is in code 4 and both tid and tag match. It then moves the thread to code 6, or to Blocked if the thread is stalled or `ctx_switch` is set. Any other response is dropped.
- R11: A squash that loads PCs drops the thread's outstanding response, and drops its ownership of a pending retry. The retry that follows only clears `cache_blocked`.
- R12: A thread in code 6 moves to Running at the next edge when `fetch_grant[t]` is set, and stays in code 6 until then.
- R13: `stage_active` is 1 after an edge exactly when some active thread holds code 0, 2 or 6.
- R14: A thread with `thr_active[t]` = 0 keeps its status, stall bits and PCs whatever its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active | input | N_THR | Threads currently scheduled |
| stg_block | input | 4*N_THR | Block pulses, index stage*N_THR+thread |
| stg_unblock | input | 4*N_THR | Unblock pulses, same indexing |
| ctx_switch | input | 1 | Context switch in progress |
| cmt_squash | input | 1 | Commit redirect valid |
| cmt_tid | input | TID_W | Thread of the commit redirect |
| cmt_pc | input | PC_W | Commit redirect PC |
| cmt_npc | input | PC_W | Commit redirect next PC |
| cmt_upc | input | UPC_W | Commit redirect micro-PC |
| rob_squashing | input | N_THR | Reorder buffer still flushing, per thread |
| dec_squash | input | 1 | Decode redirect valid |
| dec_tid | input | TID_W | Thread of the decode redirect |
| dec_pc | input | PC_W | Decode redirect PC |
| dec_npc | input | PC_W | Decode redirect next PC |
| dec_upc | input | UPC_W | Decode redirect micro-PC |
| ic_req | input | 1 | Fetch issued a cache line request |
| ic_req_tid | input | TID_W | Requesting thread |
| ic_req_tag | input | TAG_W | Tag of the request |
| ic_req_ok | input | 1 | Cache accepted the request |
| ic_retry | input | 1 | Cache retry pulse |
| ic_resp | input | 1 | Cache response valid |
| ic_resp_tid | input | TID_W | Thread of the response |
| ic_resp_tag | input | TAG_W | Tag of the response |
| fetch_grant | input | N_THR | Fetch slot given to the thread |
| thr_state | output | 4*N_THR | Status code per thread |
| thr_pc | output | N_THR*PC_W | PC per thread |
| thr_npc | output | N_THR*PC_W | Next PC per thread |
| thr_upc | output | N_THR*UPC_W | Micro-PC per thread |
| stage_active | output | 1 | Some active thread has fetch work |
| cache_blocked | output | 1 | A refused request awaits its retry |

## Verification
The hardest case to reach is a refused request whose owner is squashed before the retry arrives. After that, the retry may only clear the global flag and must not revive the thread. Directed stimulus gets there by issuing a refused request, squashing the same thread from commit, letting it return to Running, and only then raising the retry. Random traffic follows, with responses that reuse the expected tag most of the time, so that fills, stalled fills and stale drops all occur under a lockstep behavioural model.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;
  localparam int NUM_STAGES = 4;
  typedef enum logic [3:0] {
    TS_RUN          = 4'd0,
    TS_IDLE         = 4'd1,
    TS_SQUASH       = 4'd2,
    TS_BLOCKED      = 4'd3,
    TS_WAIT_RESP    = 4'd4,
    TS_WAIT_RETRY   = 4'd5,
    TS_FILL_DONE    = 4'd6,
    TS_TRAP_WAIT    = 4'd7,
    TS_QUIESCE_WAIT = 4'd8
  } tstate_e;
endpackage

// File: rtl/fetch_stall_latch.sv
module fetch_stall_latch #(
  parameter int N_THR = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [N_THR-1:0]                           active,
  input  logic [fetch_ctl_pkg::NUM_STAGES*N_THR-1:0] blk,
  input  logic [fetch_ctl_pkg::NUM_STAGES*N_THR-1:0] unblk,
  output logic [N_THR-1:0]                           stall_next
);
  localparam int NS = fetch_ctl_pkg::NUM_STAGES;
  localparam int NB = NS * N_THR;

  logic [NB-1:0] bits_q, bits_d;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [NS-1:0] col;
    for (genvar s = 0; s < NS; s++) begin : g_stg
      localparam int I = s * N_THR + t;
      assign bits_d[I] = active[t] ? ((bits_q[I] | blk[I]) & ~unblk[I]) : bits_q[I];
      assign col[s]    = bits_d[I];
      // R2: unblock is only legal on a set bit and without a block alongside it
      assert_unblock_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (active[t] && unblk[I]) |-> (bits_q[I] && !blk[I]));
    end
    assign stall_next[t] = |col;
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_d;
  end
endmodule

// File: rtl/fetch_retry_track.sv
module fetch_retry_track #(
  parameter int N_THR = 2,
  parameter int TID_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retry,
  input  logic             req_take_any,
  input  logic             req_ok,
  input  logic [TID_W-1:0] req_tid,
  input  logic [N_THR-1:0] cancel,
  output logic             cache_blocked,
  output logic [N_THR-1:0] retry_go
);
  logic             blk_q, own_v_q;
  logic [TID_W-1:0] own_q;

  assign cache_blocked = blk_q;

  for (genvar t = 0; t < N_THR; t++) begin : g_go
    assign retry_go[t] = retry && blk_q && own_v_q && (own_q == TID_W'(t)) && !cancel[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q   <= 1'b0;
      own_v_q <= 1'b0;
      own_q   <= '0;
    end else if (retry && blk_q) begin
      blk_q   <= 1'b0;
      own_v_q <= 1'b0;
    end else if (req_take_any && !req_ok) begin
      blk_q   <= 1'b1;
      own_v_q <= 1'b1;
      own_q   <= req_tid;
    end else if (own_v_q && cancel[own_q]) begin
      own_v_q <= 1'b0;
    end
  end

  assert_reject_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (req_take_any && !req_ok) |=> blk_q);
  assert_retry_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (retry && blk_q) |=> !blk_q);
endmodule

// File: rtl/fetch_thread_fsm.sv
module fetch_thread_fsm
  import fetch_ctl_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          UPC_W      = 8,
  parameter int          TAG_W      = 4,
  parameter int unsigned RESET_PC   = 0,
  parameter int unsigned INST_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             stalled,
  input  logic             ctx_switch,
  input  logic             csq,
  input  logic [PC_W-1:0]  csq_pc,
  input  logic [PC_W-1:0]  csq_npc,
  input  logic [UPC_W-1:0] csq_upc,
  input  logic             rob_sq,
  input  logic             dsq,
  input  logic [PC_W-1:0]  dsq_pc,
  input  logic [PC_W-1:0]  dsq_npc,
  input  logic [UPC_W-1:0] dsq_upc,
  input  logic             req_v,
  input  logic             req_ok,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cache_blocked,
  input  logic             retry_go,
  input  logic             resp_v,
  input  logic [TAG_W-1:0] resp_tag,
  input  logic             grant,
  output logic [3:0]       state,
  output logic [3:0]       state_next,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  npc,
  output logic [UPC_W-1:0] upc,
  output logic             req_take,
  output logic             cancel
);
  tstate_e          state_q, s1, s_d;
  logic [TAG_W-1:0] tag_q;
  logic [PC_W-1:0]  pc_q, npc_q, pc_d, npc_d;
  logic [UPC_W-1:0] upc_q, upc_d;
  logic             hold;

  assign hold = stalled || ctx_switch;

  always_comb begin
    s1     = state_q;
    pc_d   = pc_q;
    npc_d  = npc_q;
    upc_d  = upc_q;
    cancel = 1'b0;
    if (active) begin
      if (csq) begin
        s1 = TS_SQUASH; cancel = 1'b1;
        pc_d = csq_pc; npc_d = csq_npc; upc_d = csq_upc;
      end else if (rob_sq) begin
        s1 = TS_SQUASH;
      end else if (dsq && state_q != TS_SQUASH) begin
        s1 = TS_SQUASH; cancel = 1'b1;
        pc_d = dsq_pc; npc_d = dsq_npc; upc_d = dsq_upc;
      end else if (hold && state_q != TS_WAIT_RESP && state_q != TS_WAIT_RETRY) begin
        s1 = TS_BLOCKED;
      end else if (state_q == TS_BLOCKED || state_q == TS_SQUASH) begin
        s1 = TS_RUN;
      end
    end
  end

  assign req_take = active && req_v && (s1 == TS_RUN) && !cache_blocked;

  always_comb begin
    s_d = s1;
    if (!active)                                                s_d = state_q;
    else if (req_take)                                          s_d = req_ok ? TS_WAIT_RESP : TS_WAIT_RETRY;
    else if (s1 == TS_WAIT_RETRY && retry_go)                   s_d = TS_WAIT_RESP;
    else if (s1 == TS_WAIT_RESP && resp_v && resp_tag == tag_q) s_d = hold ? TS_BLOCKED : TS_FILL_DONE;
    else if (s1 == TS_FILL_DONE && grant)                       s_d = TS_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_RUN;
      tag_q   <= '0;
      pc_q    <= PC_W'(RESET_PC);
      npc_q   <= PC_W'(RESET_PC + INST_BYTES);
      upc_q   <= '0;
    end else begin
      state_q <= s_d;
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      upc_q   <= upc_d;
      if (req_take) tag_q <= req_tag;
    end
  end

  assign state      = state_q;
  assign state_next = s_d;
  assign pc         = pc_q;
  assign npc        = npc_q;
  assign upc        = upc_q;

  assert_csq_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (active && csq) |=> (state_q == TS_SQUASH));
  assert_rob_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active && !csq && rob_sq) |=> (state_q == TS_SQUASH));
  assert_blk_release_R7: assert property (@(posedge clk) disable iff (rst)
    (active && state_q == TS_BLOCKED && !csq && !rob_sq && !dsq && !hold && !req_v)
      |=> (state_q == TS_RUN));
  assert_fill_grant_R12: assert property (@(posedge clk) disable iff (rst)
    (active && state_q == TS_FILL_DONE && grant && !csq && !rob_sq && !dsq && !hold)
      |=> (state_q == TS_RUN));
  assert_inactive_hold_R14: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(state_q));
endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
  import fetch_ctl_pkg::*;
#(
  parameter int          N_THR      = 2,
  parameter int          PC_W       = 32,
  parameter int          UPC_W      = 8,
  parameter int          TAG_W      = 4,
  parameter int unsigned RESET_PC   = 0,
  parameter int unsigned INST_BYTES = 4,
  localparam int         TID_W      = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_THR-1:0]              thr_active,
  input  logic [NUM_STAGES*N_THR-1:0]   stg_block,
  input  logic [NUM_STAGES*N_THR-1:0]   stg_unblock,
  input  logic                          ctx_switch,
  input  logic                          cmt_squash,
  input  logic [TID_W-1:0]              cmt_tid,
  input  logic [PC_W-1:0]               cmt_pc,
  input  logic [PC_W-1:0]               cmt_npc,
  input  logic [UPC_W-1:0]              cmt_upc,
  input  logic [N_THR-1:0]              rob_squashing,
  input  logic                          dec_squash,
  input  logic [TID_W-1:0]              dec_tid,
  input  logic [PC_W-1:0]               dec_pc,
  input  logic [PC_W-1:0]               dec_npc,
  input  logic [UPC_W-1:0]              dec_upc,
  input  logic                          ic_req,
  input  logic [TID_W-1:0]              ic_req_tid,
  input  logic [TAG_W-1:0]              ic_req_tag,
  input  logic                          ic_req_ok,
  input  logic                          ic_retry,
  input  logic                          ic_resp,
  input  logic [TID_W-1:0]              ic_resp_tid,
  input  logic [TAG_W-1:0]              ic_resp_tag,
  input  logic [N_THR-1:0]              fetch_grant,
  output logic [4*N_THR-1:0]            thr_state,
  output logic [N_THR*PC_W-1:0]         thr_pc,
  output logic [N_THR*PC_W-1:0]         thr_npc,
  output logic [N_THR*UPC_W-1:0]        thr_upc,
  output logic                          stage_active,
  output logic                          cache_blocked
);
  logic [N_THR-1:0] stall_next, take, cancel, retry_go, runnable;
  logic             blocked_w;

  fetch_stall_latch #(.N_THR(N_THR)) u_stall (
    .clk(clk), .rst(rst), .active(thr_active),
    .blk(stg_block), .unblk(stg_unblock), .stall_next(stall_next)
  );

  fetch_retry_track #(.N_THR(N_THR), .TID_W(TID_W)) u_retry (
    .clk(clk), .rst(rst), .retry(ic_retry), .req_take_any(|take),
    .req_ok(ic_req_ok), .req_tid(ic_req_tid), .cancel(cancel),
    .cache_blocked(blocked_w), .retry_go(retry_go)
  );

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [3:0] nxt;
    fetch_thread_fsm #(
      .PC_W(PC_W), .UPC_W(UPC_W), .TAG_W(TAG_W),
      .RESET_PC(RESET_PC), .INST_BYTES(INST_BYTES)
    ) u_fsm (
      .clk(clk), .rst(rst), .active(thr_active[t]),
      .stalled(stall_next[t]), .ctx_switch(ctx_switch),
      .csq(cmt_squash && cmt_tid == TID_W'(t)),
      .csq_pc(cmt_pc), .csq_npc(cmt_npc), .csq_upc(cmt_upc),
      .rob_sq(rob_squashing[t]),
      .dsq(dec_squash && dec_tid == TID_W'(t)),
      .dsq_pc(dec_pc), .dsq_npc(dec_npc), .dsq_upc(dec_upc),
      .req_v(ic_req && ic_req_tid == TID_W'(t)),
      .req_ok(ic_req_ok), .req_tag(ic_req_tag),
      .cache_blocked(blocked_w), .retry_go(retry_go[t]),
      .resp_v(ic_resp && ic_resp_tid == TID_W'(t)), .resp_tag(ic_resp_tag),
      .grant(fetch_grant[t]),
      .state(thr_state[4*t +: 4]), .state_next(nxt),
      .pc(thr_pc[PC_W*t +: PC_W]), .npc(thr_npc[PC_W*t +: PC_W]),
      .upc(thr_upc[UPC_W*t +: UPC_W]),
      .req_take(take[t]), .cancel(cancel[t])
    );
    assign runnable[t] = thr_active[t] &&
      (nxt == TS_RUN || nxt == TS_SQUASH || nxt == TS_FILL_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) stage_active <= 1'b0;
    else     stage_active <= |runnable;
  end

  assign cache_blocked = blocked_w;

  assert_one_take_R8: assert property (@(posedge clk) disable iff (rst) $onehot0(take));
endmodule

// File: tb/fetch_thread_ctrl_test.sv
`timescale 1ns/1ps
module fetch_thread_ctrl_test;
  localparam int N = 2;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [N-1:0] thr_active, rob_squashing, fetch_grant;
  logic [4*N-1:0] stg_block, stg_unblock;
  logic ctx_switch, cmt_squash, dec_squash, ic_req, ic_req_ok, ic_retry, ic_resp;
  logic [0:0] cmt_tid, dec_tid, ic_req_tid, ic_resp_tid;
  logic [31:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [7:0] cmt_upc, dec_upc;
  logic [3:0] ic_req_tag, ic_resp_tag;
  logic [4*N-1:0] thr_state;
  logic [N*32-1:0] thr_pc, thr_npc;
  logic [N*8-1:0] thr_upc;
  logic stage_active, cache_blocked;

  fetch_thread_ctrl uut (.*);

  int vectors = 0, miscomp = 0;
  bit done = 0;
  int m_st[N];
  bit m_bits[4][N];
  logic [31:0] m_pc[N], m_npc[N];
  logic [7:0] m_upc[N];
  logic [3:0] m_tag[N];
  bit m_blk, m_ownv, m_act;
  int m_own;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    thr_active = '1; rob_squashing = '0; fetch_grant = '0;
    stg_block = '0; stg_unblock = '0; ctx_switch = 0;
    cmt_squash = 0; dec_squash = 0; ic_req = 0; ic_req_ok = 0; ic_retry = 0; ic_resp = 0;
    cmt_tid = 0; dec_tid = 0; ic_req_tid = 0; ic_resp_tid = 0;
    cmt_pc = 0; cmt_npc = 0; dec_pc = 0; dec_npc = 0; cmt_upc = 0; dec_upc = 0;
    ic_req_tag = 0; ic_resp_tag = 0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin
      m_st[t] = 0; m_pc[t] = 0; m_npc[t] = 4; m_upc[t] = 0; m_tag[t] = 0;
      for (int s = 0; s < 4; s++) m_bits[s][t] = 0;
    end
    m_blk = 0; m_ownv = 0; m_own = 0; m_act = 0;
  endtask

  task automatic model_step();
    int s1[N]; int nx[N]; bit cancel[N]; bit stl[N]; bit take; bit any;
    for (int t = 0; t < N; t++) begin
      if (thr_active[t])
        for (int s = 0; s < 4; s++) begin
          if (stg_block[s*N+t]) m_bits[s][t] = 1;
          if (stg_unblock[s*N+t]) m_bits[s][t] = 0;
        end
      stl[t] = 0;
      for (int s = 0; s < 4; s++) stl[t] |= m_bits[s][t];
      stl[t] |= ctx_switch;
      s1[t] = m_st[t]; cancel[t] = 0;
      if (thr_active[t]) begin
        if (cmt_squash && cmt_tid == t) begin
          s1[t] = 2; cancel[t] = 1; m_pc[t] = cmt_pc; m_npc[t] = cmt_npc; m_upc[t] = cmt_upc;
        end else if (rob_squashing[t]) s1[t] = 2;
        else if (dec_squash && dec_tid == t && m_st[t] != 2) begin
          s1[t] = 2; cancel[t] = 1; m_pc[t] = dec_pc; m_npc[t] = dec_npc; m_upc[t] = dec_upc;
        end else if (stl[t] && m_st[t] != 4 && m_st[t] != 5) s1[t] = 3;
        else if (m_st[t] == 3 || m_st[t] == 2) s1[t] = 0;
      end
    end
    take = ic_req && thr_active[ic_req_tid] && s1[ic_req_tid] == 0 && !m_blk;
    for (int t = 0; t < N; t++) begin
      nx[t] = s1[t];
      if (!thr_active[t]) nx[t] = m_st[t];
      else if (take && ic_req_tid == t) begin nx[t] = ic_req_ok ? 4 : 5; m_tag[t] = ic_req_tag; end
      else if (s1[t] == 5 && ic_retry && m_blk && m_ownv && m_own == t && !cancel[t]) nx[t] = 4;
      else if (s1[t] == 4 && ic_resp && ic_resp_tid == t && ic_resp_tag == m_tag[t]) nx[t] = stl[t] ? 3 : 6;
      else if (s1[t] == 6 && fetch_grant[t]) nx[t] = 0;
    end
    if (ic_retry && m_blk) begin m_blk = 0; m_ownv = 0; end
    else if (take && !ic_req_ok) begin m_blk = 1; m_ownv = 1; m_own = ic_req_tid; end
    else if (m_ownv && cancel[m_own]) m_ownv = 0;
    any = 0;
    for (int t = 0; t < N; t++) begin
      m_st[t] = nx[t];
      if (thr_active[t] && (nx[t] == 0 || nx[t] == 2 || nx[t] == 6)) any = 1;
    end
    m_act = any;
  endtask

  task automatic compare();
    for (int t = 0; t < N; t++) begin
      chk($sformatf("R1 model state thread%0d", t), thr_state[4*t +: 4], m_st[t]);
      chk($sformatf("R3 model pc thread%0d", t), thr_pc[32*t +: 32], m_pc[t]);
      chk($sformatf("R5 model npc thread%0d", t), thr_npc[32*t +: 32], m_npc[t]);
      chk($sformatf("R3 model upc thread%0d", t), thr_upc[8*t +: 8], m_upc[t]);
    end
    chk("R8 model cache_blocked", cache_blocked, m_blk);
    chk("R13 model stage_active", stage_active, m_act);
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk); #1;
    compare();
    idle_inputs();
  endtask

  function automatic logic [3:0] st(input int t);
    return thr_state[4*t +: 4];
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    idle_inputs(); model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    compare();
    chk("R1 reset state0", st(0), 0); chk("R1 reset blocked", cache_blocked, 0);
    chk("R1 reset active", stage_active, 0);
    cycle(); chk("R13 active after reset", stage_active, 1);

    // R3: commit squash beats decode squash and block in the same cycle
    cmt_squash = 1; cmt_tid = 0; cmt_pc = 32'h100; cmt_npc = 32'h104; cmt_upc = 3;
    dec_squash = 1; dec_tid = 0; dec_pc = 32'h900; stg_block[0] = 1;
    cycle(); chk("R3 state", st(0), 2); chk("R3 pc", thr_pc[31:0], 32'h100);
    // R5 ignored while squashing, R7 return to running
    dec_squash = 1; dec_tid = 0; dec_pc = 32'h900; stg_unblock[0] = 1;
    cycle(); chk("R5 pc kept", thr_pc[31:0], 32'h100); chk("R7 running", st(0), 0);
    dec_squash = 1; dec_tid = 1; dec_pc = 32'h200; dec_npc = 32'h204;
    cycle(); chk("R5 decode squash", st(1), 2); chk("R5 pc", thr_pc[63:32], 32'h200);
    rob_squashing = 2'b10; dec_squash = 1; dec_tid = 1; dec_pc = 32'h500;
    cycle(); chk("R4 held", st(1), 2); chk("R4 pc kept", thr_pc[63:32], 32'h200);
    cycle(); chk("R7 squash ends", st(1), 0);
    // R2 / R6 stall bits and context switch
    stg_block[4] = 1;
    cycle(); chk("R6 blocked", st(0), 3);
    cycle(); chk("R2 sticky", st(0), 3);
    stg_unblock[4] = 1;
    cycle(); chk("R2 unblock", st(0), 0);
    ctx_switch = 1;
    cycle(); chk("R6 ctx thread1", st(1), 3);
    cycle(); chk("R7 ctx release", st(1), 0);
    // R8 / R9 / R10 refusal, retry and response filtering
    ic_req = 1; ic_req_tid = 0; ic_req_tag = 1; ic_req_ok = 0;
    cycle(); chk("R8 refused", st(0), 5); chk("R8 flag", cache_blocked, 1);
    ic_req = 1; ic_req_tid = 1; ic_req_ok = 1;
    cycle(); chk("R8 ignored while blocked", st(1), 0);
    stg_block[0] = 1;
    cycle(); chk("R6 exempt in retry wait", st(0), 5);
    ic_retry = 1;
    cycle(); chk("R9 to response wait", st(0), 4); chk("R9 flag cleared", cache_blocked, 0);
    ic_resp = 1; ic_resp_tid = 0; ic_resp_tag = 9;
    cycle(); chk("R10 tag mismatch dropped", st(0), 4);
    ic_resp = 1; ic_resp_tid = 0; ic_resp_tag = 1;
    cycle(); chk("R10 stalled fill", st(0), 3);
    stg_unblock[0] = 1;
    cycle(); chk("R7 after fill", st(0), 0);
    // R11 squash cancels outstanding response and retry ownership
    ic_req = 1; ic_req_tid = 0; ic_req_tag = 5; ic_req_ok = 1;
    cycle(); chk("R8 accepted", st(0), 4);
    cmt_squash = 1; cmt_tid = 0; cmt_pc = 32'h300; cmt_npc = 32'h304;
    cycle(); chk("R11 squash", st(0), 2);
    cycle();
    ic_resp = 1; ic_resp_tid = 0; ic_resp_tag = 5;
    cycle(); chk("R11 stale response", st(0), 0);
    ic_req = 1; ic_req_tid = 1; ic_req_tag = 2; ic_req_ok = 0;
    cycle(); chk("R8 refused thread1", st(1), 5);
    cmt_squash = 1; cmt_tid = 1; cmt_pc = 32'h400;
    cycle(); chk("R11 flag stays", cache_blocked, 1);
    cycle();
    ic_retry = 1;
    cycle(); chk("R11 retry clears only", cache_blocked, 0); chk("R11 owner not revived", st(1), 0);
    // R12 fill completion and grant
    ic_req = 1; ic_req_tid = 0; ic_req_tag = 3; ic_req_ok = 1;
    cycle();
    ic_resp = 1; ic_resp_tid = 0; ic_resp_tag = 3;
    cycle(); chk("R10 fill done", st(0), 6);
    cycle(); chk("R12 waits for grant", st(0), 6);
    fetch_grant = 2'b01;
    cycle(); chk("R12 granted", st(0), 0);
    // R14 inactive thread, R13 stage idle
    thr_active = 2'b01; stg_block[4] = 1; cmt_squash = 1; cmt_tid = 1; cmt_pc = 32'h777;
    cycle(); chk("R14 state kept", st(1), 0); chk("R14 pc kept", thr_pc[63:32], 32'h400);
    chk("R13 no work", stage_active, 0);
    stg_unblock[4] = 1;
    cycle(); chk("R13 work again", stage_active, 1);

    // random traffic under the model
    for (int i = 0; i < 4000; i++) begin
      thr_active = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b11;
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < N; t++) begin
          stg_block[s*N+t] = ($urandom_range(0, 99) < 6);
          stg_unblock[s*N+t] = m_bits[s][t] && !stg_block[s*N+t] && ($urandom_range(0, 99) < 25);
        end
      ctx_switch = ($urandom_range(0, 99) < 3);
      cmt_squash = ($urandom_range(0, 99) < 5); cmt_tid = 1'($urandom);
      cmt_pc = $urandom; cmt_npc = $urandom; cmt_upc = 8'($urandom);
      dec_squash = ($urandom_range(0, 99) < 8); dec_tid = 1'($urandom);
      dec_pc = $urandom; dec_npc = $urandom; dec_upc = 8'($urandom);
      rob_squashing = {($urandom_range(0, 99) < 5), ($urandom_range(0, 99) < 5)};
      ic_req = ($urandom_range(0, 99) < 40); ic_req_tid = 1'($urandom);
      ic_req_tag = 4'($urandom); ic_req_ok = ($urandom_range(0, 99) < 70);
      ic_retry = ($urandom_range(0, 99) < 20);
      ic_resp = ($urandom_range(0, 99) < 35); ic_resp_tid = 1'($urandom);
      ic_resp_tag = ($urandom_range(0, 99) < 75) ? m_tag[ic_resp_tid] : 4'($urandom);
      fetch_grant = 2'($urandom);
      cycle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule